// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block decides whether a processor takes a device interrupt. It holds a 3-bit processor priority level and, for each device source, a pending request flag and a programmable 3-bit priority. Every cycle it looks for pending sources whose priority is strictly above the processor level. When the global enable is high, the strongest of these is taken. Strength is decided by the highest priority first, then by the lowest source number.

On a take, the gate does four things. It pulses a valid flag and reports the source number. It presents the level that was in force, so that level can be pushed to the stack. It raises the processor level to the priority of the source it took. It clears that source's pending flag. Because the processor level has been raised, only a strictly higher priority can interrupt the handler, so interrupts can nest.

When a handler returns, a restore strobe loads the saved level back into the processor level.

Top module: `irq_level_gate`

## Requirements
- R1: After reset the processor level is 0, no request is pending, every source priority is 0, and the take outputs are 0.
- R2: A pending source is taken only when int_en is 1 and its priority is strictly greater than the current processor level. A source with priority 0 is therefore never taken.
- R3: Among eligible sources, the highest priority wins. Among sources of equal priority, the lowest source index wins.
- R4: A take decided at a clock edge shows after that edge as take_valid=1 for exactly one cycle. In that cycle take_idx holds the source index and saved_lvl holds the processor level from before the take.
- R5: After a take, cur_lvl equals the priority of the taken source. Otherwise cur_lvl changes only through a restore.
- R6: The pending flag of a taken source is cleared at the take edge. A req_set bit for that same source in the same cycle leaves the flag set. The req_set bits of other sources OR into pending.
- R7: A cycle with restore_we=1 loads restore_lvl into cur_lvl and blocks any take in that cycle.
- R8: A cycle with cfg_we=1 writes cfg_lvl as the priority of source cfg_idx. The new value is used from the next cycle; a take in the write cycle uses the old priority.
- R9: While int_en is 0 nothing is taken, and pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 1 | Global acceptance enable |
| req_set | input | NSRC | Per-source request set pulses |
| cfg_we | input | 1 | Priority write strobe |
| cfg_idx | input | IW | Source to program |
| cfg_lvl | input | LW | Priority value to write |
| restore_we | input | 1 | Processor level restore strobe |
| restore_lvl | input | LW | Level to restore |
| take_valid | output | 1 | One-cycle take pulse |
| take_idx | output | IW | Index of taken source |
| saved_lvl | output | LW | Processor level before the take |
| cur_lvl | output | LW | Current processor level |
| pending | output | NSRC | Pending request flags |

## Verification
The hard cases are reached through the restore strobe. Restore sets the processor level to any value in a single cycle, so every combination of processor level, priority pattern and pending mask can be reached. The sweep uses this to cover all eight levels, including the boundary where a source's priority exactly equals the processor level. Directed sequences force the collisions a normal flow rarely produces: a restore in the same cycle as an eligible request, a new request from the source being taken, and a priority write in the cycle it would be used. A nesting sequence checks that a lower request stays blocked until the level is restored.

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int NSRC = 4,
  parameter int LW   = 3,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            int_en,
  input  logic [NSRC-1:0] req_set,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [LW-1:0]   cfg_lvl,
  input  logic            restore_we,
  input  logic [LW-1:0]   restore_lvl,
  output logic            take_valid,
  output logic [IW-1:0]   take_idx,
  output logic [LW-1:0]   saved_lvl,
  output logic [LW-1:0]   cur_lvl,
  output logic [NSRC-1:0] pending
);

  logic [LW-1:0]   prio_q [NSRC];
  logic [LW-1:0]   best_lvl;
  logic [IW-1:0]   best_idx;
  logic            hit;
  logic            accept;
  logic [NSRC-1:0] clr;

  always_comb begin
    best_lvl = cur_lvl;
    best_idx = '0;
    hit      = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (pending[s] && prio_q[s] > best_lvl) begin
        best_lvl = prio_q[s];
        best_idx = IW'(s);
        hit      = 1'b1;
      end
    end
  end

  assign accept = int_en && hit && !restore_we;
  assign clr    = accept ? (NSRC'(1) << best_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) prio_q[s] <= '0;
    end else if (cfg_we) begin
      prio_q[cfg_idx] <= cfg_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= '0;
      cur_lvl    <= '0;
      take_valid <= 1'b0;
      take_idx   <= '0;
      saved_lvl  <= '0;
    end else begin
      pending    <= (pending & ~clr) | req_set;
      take_valid <= accept;
      if (restore_we) begin
        cur_lvl <= restore_lvl;
      end else if (accept) begin
        cur_lvl   <= best_lvl;
        take_idx  <= best_idx;
        saved_lvl <= cur_lvl;
      end
    end
  end

endmodule

// File: rtl/irq_level_gate_chk.sv
module irq_level_gate_chk #(
  parameter int NSRC = 4,
  parameter int LW   = 3,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            int_en,
  input logic [NSRC-1:0] req_set,
  input logic            restore_we,
  input logic [LW-1:0]   restore_lvl,
  input logic            take_valid,
  input logic [IW-1:0]   take_idx,
  input logic [LW-1:0]   saved_lvl,
  input logic [LW-1:0]   cur_lvl,
  input logic [NSRC-1:0] pending
);

  AST_TAKE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (cur_lvl > saved_lvl)); // R2

  AST_SAVED_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (saved_lvl == $past(cur_lvl))); // R4

  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_valid && !$past(restore_we)) |-> $stable(cur_lvl)); // R5

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (!pending[take_idx] || (($past(req_set) >> take_idx) & NSRC'(1)) != '0)); // R6

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_we |=> (cur_lvl == $past(restore_lvl) && !take_valid)); // R7

  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !take_valid); // R9

endmodule

bind irq_level_gate irq_level_gate_chk #(.NSRC(NSRC), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_en(int_en), .req_set(req_set),
  .restore_we(restore_we), .restore_lvl(restore_lvl),
  .take_valid(take_valid), .take_idx(take_idx), .saved_lvl(saved_lvl),
  .cur_lvl(cur_lvl), .pending(pending)
);

// File: tb/test_irq_level_gate.sv
`timescale 1ns/1ps
module test_irq_level_gate;
  localparam int NSRC = 4;
  localparam int LW   = 3;
  localparam int IW   = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            int_en;
  logic [NSRC-1:0] req_set;
  logic            cfg_we;
  logic [IW-1:0]   cfg_idx;
  logic [LW-1:0]   cfg_lvl;
  logic            restore_we;
  logic [LW-1:0]   restore_lvl;
  logic            take_valid;
  logic [IW-1:0]   take_idx;
  logic [LW-1:0]   saved_lvl;
  logic [LW-1:0]   cur_lvl;
  logic [NSRC-1:0] pending;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_level_gate #(.NSRC(NSRC), .LW(LW)) i_irq_level_gate (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .req_set(req_set),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .restore_we(restore_we), .restore_lvl(restore_lvl),
    .take_valid(take_valid), .take_idx(take_idx), .saved_lvl(saved_lvl),
    .cur_lvl(cur_lvl), .pending(pending)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    int_en = 0; req_set = '0; cfg_we = 0; cfg_idx = '0; cfg_lvl = '0;
    restore_we = 0; restore_lvl = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic prog(input int s, input int l);
    cfg_we = 1; cfg_idx = IW'(s); cfg_lvl = LW'(l); tick();
  endtask

  function automatic int pat(input int p, input int s);
    if (p < 4) return (p * 3 + s * 5 + p * s) % 8;
    if (p == 4) return 3;
    return (s == 2) ? 2 : 6;
  endfunction

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 cur_lvl", cur_lvl, 0);
    check("R1 pending", pending, 0);
    check("R1 take_valid", take_valid, 0);
    check("R1 saved_lvl", saved_lvl, 0);
    // R1 priorities at zero: a pending source is never taken
    req_set = 4'hF; tick();
    int_en = 1; tick();
    check("R1 zero priorities", take_valid, 0);

    // Sweep: R2 R3 R4 R5 R6 R9
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int m = 0; m < 16; m++) begin
          int best, win;
          do_reset();
          for (int s = 0; s < NSRC; s++) prog(s, pat(p, s));
          restore_we = 1; restore_lvl = LW'(c); tick();
          req_set = NSRC'(m); tick();
          check("R9 pending held", pending, m);
          check("R7 restored level", cur_lvl, c);
          best = c; win = -1;
          for (int s = 0; s < NSRC; s++)
            if (m[s] && pat(p, s) > best) best = pat(p, s);
          for (int s = NSRC - 1; s >= 0; s--)
            if (m[s] && pat(p, s) == best && best > c) win = s;
          int_en = 1; tick();
          if (win >= 0) begin
            check("R2 taken", take_valid, 1);
            check("R3 index", take_idx, win);
            check("R4 saved level", saved_lvl, c);
            check("R5 new level", cur_lvl, best);
            check("R6 flag cleared", pending, m & ~(1 << win));
            tick();
            check("R4 single pulse", take_valid, 0);
          end else begin
            check("R2 not taken", take_valid, 0);
            check("R5 level kept", cur_lvl, c);
            check("R2 pending kept", pending, m);
          end
        end
      end
    end

    // R7 restore blocks a take in the same cycle
    do_reset();
    prog(1, 6);
    req_set = 4'b0010; tick();
    int_en = 1; restore_we = 1; restore_lvl = 3'd2; tick();
    check("R7 no take", take_valid, 0);
    check("R7 level", cur_lvl, 2);
    check("R7 pending kept", pending, 4'b0010);
    int_en = 1; tick();
    check("R7 later take", take_valid, 1);
    check("R7 saved", saved_lvl, 2);

    // R6 set and take of the same source in one cycle
    do_reset();
    prog(2, 4);
    req_set = 4'b0100; tick();
    int_en = 1; req_set = 4'b0101; tick();
    check("R6 take", take_idx, 2);
    check("R6 re-set flag kept", pending, 4'b0101);

    // R8 write in the take cycle uses the old priority
    do_reset();
    prog(0, 2);
    req_set = 4'b0001; tick();
    int_en = 1; cfg_we = 1; cfg_idx = 0; cfg_lvl = 3'd5; tick();
    check("R8 old priority used", cur_lvl, 2);
    restore_we = 1; restore_lvl = 0; req_set = 4'b0001; tick();
    int_en = 1; tick();
    check("R8 new priority used", cur_lvl, 5);

    // R5 nesting: lower request waits for restore
    do_reset();
    prog(0, 2); prog(1, 5);
    req_set = 4'b0011; tick();
    int_en = 1; tick();
    check("R5 nest first", take_idx, 1);
    int_en = 1; tick();
    check("R5 lower blocked", take_valid, 0);
    check("R5 lower pending", pending, 4'b0001);
    restore_we = 1; restore_lvl = 0; tick();
    int_en = 1; tick();
    check("R5 lower after restore", take_idx, 0);
    check("R5 level", cur_lvl, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule